// File: doc/BRIEF.md
# Conditional-Subtract Sequential Divider

This unit divides an unsigned dividend of twice the word width by an unsigned divisor of one word width. It produces a one-word quotient and a one-word remainder. The dividend is split into a high word held in a partial-remainder register and a low word held in a shift register. That shift register fills with quotient bits as the division proceeds.

Each quotient bit takes two clock cycles. In the first, the pair of registers moves left by one place and the pending quotient bit enters the low end. In the second, the divisor's one's complement plus one is added to the partial remainder. The sum is kept only when that addition carries out, and the carry is latched as the next quotient bit. Before any step runs, a range check rejects operand pairs whose quotient would not fit in one word and ends the operation at once with an overflow flag. Sign handling is left to the surrounding logic.

A caller pulses `start` with the operands, waits for the one-cycle `done` pulse, and then reads `quotient`, `remainder` and `overflow`. These stay stable until the next accepted start.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `done`, `overflow`, `quotient` and `remainder` are all 0.
- R2: When the high word of `dividend` (bits 31:16) is smaller than `divisor`, the result at `done` is `quotient` = dividend / divisor and `remainder` = dividend mod divisor. Both are unsigned, and `overflow` is 0.
- R3: When the high word of `dividend` is greater than or equal to `divisor`, the result at `done` has `overflow` = 1, `quotient` = 0 and `remainder` = 0. A zero divisor always falls in this case.
- R4: Count the rising edge that samples `start` as edge 0. A division without overflow raises `done` after edge 34 (2 cycles per quotient bit plus 2). An overflowing one raises `done` after edge 1.
- R5: `done` is high for exactly one cycle. `quotient`, `remainder` and `overflow` keep their values after `done` until another start is accepted.
- R6: A `start` that arrives while an operation is in progress is ignored. The result and the latency are those of the operation already running.
- R7: A `start` given in the cycle where `done` is high is accepted. In that same cycle the outputs still show the finished result, and the new operation then runs with the latency of R4.
- R8: The result is correct even when the shifted partial remainder needs one bit more than a word, for example dividend 0xFFFEFFFF with divisor 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a division with the present operands |
| dividend | input | 32 | Unsigned dividend, high word in bits 31:16 |
| divisor | input | 16 | Unsigned divisor |
| quotient | output | 16 | Quotient, valid from `done` |
| remainder | output | 16 | Remainder, valid from `done` |
| overflow | output | 1 | Quotient would not fit, or the divisor is zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can fall in the same cycle are reporting a finished result and accepting a new request. The bench raises `start` in the very cycle it first sees `done`. In that cycle it checks that the old quotient is still on the outputs. It then checks that the new operands give their own result after the full step count. A second scenario re-raises `start` in the middle of a running division. It is judged by getting the first operation's result at its normal latency.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_SHIFT = 3'd2,
      ST_SUB   = 3'd3,
      ST_FINAL = 3'd4,
      ST_DONE  = 3'd5
   } dstate_e;

   localparam int SUB_COMPLEMENT_ADD = 0;
   localparam int SUB_DIRECT_COMPARE = 1;

endpackage

// File: rtl/divstep_range_check.sv
module divstep_range_check #(
   parameter int QW = 16
) (
   input  logic [QW-1:0] hi_word,
   input  logic [QW-1:0] dvr,
   output logic          too_big
);
   generate
      if (QW < 2) begin : g_bad_width
         $error("divstep_range_check: QW must be at least 2");
      end
   endgenerate

   // Quotient fits in QW bits only when the high word is below the divisor;
   // a zero divisor therefore always trips this.
   always_comb begin
      too_big = (hi_word >= dvr);
   end
endmodule

// File: rtl/divstep_cond_sub.sv
module divstep_cond_sub #(
   parameter int QW        = 16,
   parameter int SUB_STYLE = 0
) (
   input  logic [QW:0]   prem,
   input  logic [QW-1:0] dvr,
   output logic          take,
   output logic [QW-1:0] diff
);
   import divstep_pkg::*;

   generate
      if (SUB_STYLE != SUB_COMPLEMENT_ADD && SUB_STYLE != SUB_DIRECT_COMPARE) begin : g_bad_style
         $error("divstep_cond_sub: unknown SUB_STYLE");
      end

      if (SUB_STYLE == SUB_COMPLEMENT_ADD) begin : g_cadd
         logic [QW:0] sum;
         always_comb begin
            // low word plus inverted divisor plus one; the extra top bit of
            // the partial remainder counts as an extra carry
            sum  = {1'b0, prem[QW-1:0]} + {1'b0, ~dvr} + {{QW{1'b0}}, 1'b1};
            take = sum[QW] | prem[QW];
            diff = sum[QW-1:0];
         end
      end else begin : g_cmp
         logic [QW:0] wide;
         always_comb begin
            wide = prem - {1'b0, dvr};
            take = (prem >= {1'b0, dvr});
            diff = wide[QW-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/divstep_seq.sv
module divstep_seq #(
   parameter int QW = 16,
   localparam int CW = (QW > 2) ? $clog2(QW) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    too_big,
   output divstep_pkg::dstate_e    state,
   output logic [CW-1:0]           steps_left,
   output logic                    accept
);
   import divstep_pkg::*;

   localparam logic [CW-1:0] LAST_STEP = CW'(QW - 1);

   always_comb begin
      accept = start && (state == ST_IDLE || state == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         steps_left <= '0;
      end else if (accept) begin
         state <= ST_CHECK;
      end else begin
         unique case (state)
            ST_CHECK: begin
               steps_left <= LAST_STEP;
               state      <= too_big ? ST_DONE : ST_SHIFT;
            end
            ST_SHIFT: state <= ST_SUB;
            ST_SUB: begin
               if (steps_left == '0) begin
                  state <= ST_FINAL;
               end else begin
                  steps_left <= steps_left - 1'b1;
                  state      <= ST_SHIFT;
               end
            end
            ST_FINAL: state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // R5: completion is a single-cycle event
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> (state != ST_DONE));

   // R4: the shift half of a bit never consumes a step
   assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |=> (steps_left == $past(steps_left)));

   // R3: an out-of-range pair goes straight to completion
   assert_early_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && too_big) |=> (state == ST_DONE));

   // R6: a request while busy never restarts the range check
   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state != ST_IDLE && state != ST_DONE) |=> (state != ST_CHECK));
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit #(
   parameter int QW        = 16,
   parameter int SUB_STYLE = 0,
   localparam int DW = 2 * QW,
   localparam int CW = (QW > 2) ? $clog2(QW) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [QW-1:0] divisor,
   output logic [QW-1:0] quotient,
   output logic [QW-1:0] remainder,
   output logic          overflow,
   output logic          done
);
   import divstep_pkg::*;

   generate
      if (QW < 2) begin : g_bad_width
         $error("divstep_unit: QW must be at least 2");
      end
   endgenerate

   dstate_e       state;
   logic [CW-1:0] steps_left;
   logic          accept;
   logic          too_big;
   logic          take;
   logic [QW-1:0] diff;

   logic [QW:0]   prem;     // partial remainder with one guard bit
   logic [QW-1:0] low_q;    // low dividend word, becomes the quotient
   logic [QW-1:0] dvr_q;
   logic          link;
   logic          ovf_q;

   divstep_seq #(.QW(QW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .too_big    (too_big),
      .state      (state),
      .steps_left (steps_left),
      .accept     (accept)
   );

   divstep_range_check #(.QW(QW)) u_range (
      .hi_word (prem[QW-1:0]),
      .dvr     (dvr_q),
      .too_big (too_big)
   );

   divstep_cond_sub #(.QW(QW), .SUB_STYLE(SUB_STYLE)) u_sub (
      .prem (prem),
      .dvr  (dvr_q),
      .take (take),
      .diff (diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prem  <= '0;
         low_q <= '0;
         dvr_q <= '0;
         link  <= 1'b0;
         ovf_q <= 1'b0;
      end else if (accept) begin
         prem  <= {1'b0, dividend[DW-1:QW]};
         low_q <= dividend[QW-1:0];
         dvr_q <= divisor;
         link  <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         unique case (state)
            ST_CHECK: begin
               link <= 1'b0;
               if (too_big) begin
                  ovf_q <= 1'b1;
                  prem  <= '0;
                  low_q <= '0;
               end
            end
            ST_SHIFT: begin
               prem  <= {prem[QW-1:0], low_q[QW-1]};
               low_q <= {low_q[QW-2:0], link};
            end
            ST_SUB: begin
               link <= take;
               if (take) begin
                  prem <= {1'b0, diff};
               end
            end
            ST_FINAL: begin
               low_q <= {low_q[QW-2:0], link};
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      quotient  = low_q;
      remainder = prem[QW-1:0];
      overflow  = ovf_q;
      done      = (state == ST_DONE);
   end

   // R8: the latched quotient bit matches a full-width comparison
   assert_link_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUB) |=> (link == ($past(prem) >= {1'b0, $past(dvr_q)})));

   // R2: a good result always leaves a remainder below the divisor
   assert_rem_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !overflow) |-> (remainder < dvr_q));

   // R3: an overflow result carries zeroed data words
   assert_no_overflow_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && overflow) |-> (quotient == '0 && remainder == '0));

   // R5: data stays put from completion until a new request
   assert_hold_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(overflow)));
endmodule

// File: tb/divstep_unit_test.sv
module divstep_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic [15:0] quotient;
   logic [15:0] remainder;
   logic        overflow;
   logic        done;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   divstep_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dividend  (dividend),
      .divisor   (divisor),
      .quotient  (quotient),
      .remainder (remainder),
      .overflow  (overflow),
      .done      (done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // counts negedges after start is raised; start is dropped after the first
   task automatic wait_done(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         start = 1'b0;
         if (done) break;
         if (n > 200) begin
            failures++;
            $display("FAIL R4 actual=timeout expected=done");
            break;
         end
      end
   endtask

   task automatic launch(input logic [31:0] dvd, input logic [15:0] dvr);
      dividend = dvd;
      divisor  = dvr;
      start    = 1'b1;
   endtask

   task automatic t_reset();
      check("R1 done", done, 0);
      check("R1 overflow", overflow, 0);
      check("R1 quotient", quotient, 0);
      check("R1 remainder", remainder, 0);
   endtask

   task automatic t_divide(input logic [31:0] dvd, input logic [15:0] dvr, input string req);
      int n;
      logic [31:0] eq, er;
      eq = dvd / {16'b0, dvr};
      er = dvd % {16'b0, dvr};
      launch(dvd, dvr);
      wait_done(n);
      check({req, " R2 quotient"}, quotient, eq);
      check({req, " R2 remainder"}, remainder, er);
      check({req, " R2 overflow"}, overflow, 0);
      check({req, " R4 latency"}, n, 35);
   endtask

   task automatic t_overflow(input logic [31:0] dvd, input logic [15:0] dvr);
      int n;
      launch(dvd, dvr);
      wait_done(n);
      check("R3 overflow", overflow, 1);
      check("R3 quotient", quotient, 0);
      check("R3 remainder", remainder, 0);
      check("R4 overflow latency", n, 2);
   endtask

   task automatic t_hold();
      logic [15:0] q0, r0;
      t_divide(32'h0012_3456, 16'h0abc, "hold");
      q0 = quotient;
      r0 = remainder;
      @(negedge clk);
      check("R5 done pulse width", done, 0);
      dividend = 32'hffff_ffff;
      divisor  = 16'h0001;
      repeat (4) @(negedge clk);
      check("R5 quotient held", quotient, q0);
      check("R5 remainder held", remainder, r0);
      check("R5 overflow held", overflow, 0);
   endtask

   task automatic t_busy();
      int n;
      launch(32'h0000_9c40, 16'h0007);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         start = (n == 6);
         if (n == 6) begin
            dividend = 32'h0000_0001;
            divisor  = 16'h0000;
         end
         if (done || n > 200) break;
      end
      check("R6 latency unchanged", n, 35);
      check("R6 quotient of first op", quotient, 32'h9c40 / 7);
      check("R6 remainder of first op", remainder, 32'h9c40 % 7);
      check("R6 no overflow", overflow, 0);
   endtask

   task automatic t_back_to_back();
      int n;
      launch(32'h0003_0000, 16'h0010);
      wait_done(n);
      launch(32'h0000_0036, 16'h0007);
      check("R7 old quotient in done cycle", quotient, 32'h0003_0000 / 16);
      check("R7 old remainder in done cycle", remainder, 0);
      wait_done(n);
      check("R7 new quotient", quotient, 7);
      check("R7 new remainder", remainder, 5);
      check("R7 new latency", n, 35);
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      t_divide(32'h0000_0036, 16'h0007, "small");
      t_divide(32'h0000_0000, 16'h0001, "zero dividend");
      t_divide(32'h0000_ffff, 16'h0001, "unit divisor");
      t_divide(32'h7fff_ffff, 16'h8000, "half range");
      t_divide(32'hfffe_ffff, 16'hffff, "R8 guard bit");
      t_divide(32'h8000_0000, 16'h8001, "R8 wide remainder");
      t_divide(32'hfffe_0001, 16'hffff, "R8 exact");

      t_overflow(32'h1234_5678, 16'h0000);
      t_overflow(32'h0000_0005, 16'h0000);
      t_overflow(32'h0010_0000, 16'h0010);
      t_overflow(32'hffff_0000, 16'h1234);

      t_hold();
      t_busy();
      t_back_to_back();

      for (int i = 0; i < 20; i++) begin
         logic [15:0] dvr;
         logic [15:0] hi;
         dvr = 16'($urandom) | 16'h0001;
         hi  = 16'($urandom % {16'b0, dvr});
         t_divide({hi, 16'($urandom)}, dvr, "R2 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule